// File: doc/BRIEF.md
# Downward-Growing Stack Pointer Unit

This block holds the stack pointer of a small 8-bit processor. The stack grows toward lower addresses. The core drives the unit through four one-hot strobes: byte push, byte pop, call or interrupt entry, and return. For every stack access the unit supplies the SRAM address, a write enable and a byte-select. Byte pushes and pops take one cycle each.

Saving or restoring a return address takes two consecutive cycles, one byte per cycle. During the second cycle the unit raises a busy output. Software sees the pointer as two 8-bit read/write registers, high and low, and writes each of them separately.

The unit also keeps a sticky warning flag. The flag is set whenever a stack step leaves the pointer at or below the bottom of the legal stack region, address 0x0100.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset the pointer reads 0x0000, and busy_o, op_err_o, mem_valid_o and limit_flag_o are all 0.
- R2: A lone byte push presents address SP with mem_we_o=1 and mem_hi_o=0 in the same cycle. The pointer then becomes SP-1.
- R3: A lone byte pop first raises the pointer. It presents address SP+1 with mem_we_o=0 in the same cycle, and the pointer becomes SP+1.
- R4: A call/interrupt strobe takes two cycles. The first cycle writes address SP with mem_hi_o=0 (low byte) and busy_o=0. The next cycle writes SP-1 with mem_hi_o=1 (high byte) and busy_o=1. The final pointer is SP-2.
- R5: A return strobe takes two cycles. The first cycle reads SP+1 with mem_hi_o=1 and busy_o=0. The next cycle reads SP+2 with mem_hi_o=0 and busy_o=1. The final pointer is SP+2.
- R6: Bit 1 of io_we_i loads io_wdata_i into pointer bits 15..8. Bit 0 loads it into bits 7..0. Each write takes effect at the next edge, and the other byte is kept unchanged.
- R7: An I/O write has priority over any stack operation in the same cycle, including the second step of a two-cycle sequence. That operation is discarded: mem_valid_o=0, the pointer changes only by the I/O write, and the unit returns to idle.
- R8: If more than one strobe is asserted while idle, op_err_o is 1 in that cycle, mem_valid_o is 0 and the pointer is unchanged.
- R9: A strobe asserted while busy_o=1 raises op_err_o and is ignored. The sequence in progress finishes normally.
- R10: limit_flag_o becomes 1 after any stack step that leaves the pointer at or below 0x0100. It then stays 1 until reset. I/O writes never set it.
- R11: Pointer arithmetic wraps modulo 2^16 with no stall. A pop from 0xFFFF reads address 0x0000, and a push from 0x0000 leaves 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Byte push strobe |
| pop_i | input | 1 | Byte pop strobe |
| call_i | input | 1 | Call / interrupt entry strobe |
| ret_i | input | 1 | Return strobe |
| io_we_i | input | 2 | I/O byte writes: bit 1 high byte, bit 0 low byte |
| io_wdata_i | input | 8 | I/O write data |
| sp_rd_o | output | 16 | Pointer read value (high register = bits 15..8) |
| mem_addr_o | output | 16 | Stack SRAM address for this cycle |
| mem_valid_o | output | 1 | A stack access takes place this cycle |
| mem_we_o | output | 1 | 1 = write (push), 0 = read (pop) |
| mem_hi_o | output | 1 | 1 = high byte of a return address |
| busy_o | output | 1 | Second step of a two-cycle sequence |
| op_err_o | output | 1 | Strobe conflict or strobe while busy |
| limit_flag_o | output | 1 | Sticky stack-limit warning |

## Verification
Two situations are hard to reach from the ports because both depend on the hidden second step of a call or return. The first is a new strobe arriving during that step. The second is an I/O write landing on that step.

The bench issues a call and then drives a push on the very next cycle, at the moment busy_o is first high. It checks that the second byte still goes to SP-1 and that op_err_o rises. In a separate call sequence it writes the high I/O register during the second step. It checks that no access appears and that the pointer holds the first-step value with the new high byte.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CALL2 = 2'd1,
    ST_RET2  = 2'd2
  } sp_seq_t;
endpackage

// File: rtl/sp_seq.sv
module sp_seq
  import sp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic push_i,
  input  logic pop_i,
  input  logic call_i,
  input  logic ret_i,
  input  logic io_any_i,
  output logic step_dn_o,
  output logic step_up_o,
  output logic acc_hi_o,
  output logic busy_o,
  output logic err_o
);
  sp_seq_t st_q, st_d;
  logic [2:0] n_strb;
  logic       one_strb;

  assign n_strb   = {2'b00, push_i} + {2'b00, pop_i} + {2'b00, call_i} + {2'b00, ret_i};
  assign one_strb = (n_strb == 3'd1);
  assign busy_o   = (st_q != ST_IDLE);
  assign err_o    = (n_strb > 3'd1) || (busy_o && (n_strb != 3'd0));

  always_comb begin
    st_d      = st_q;
    step_dn_o = 1'b0;
    step_up_o = 1'b0;
    acc_hi_o  = 1'b0;
    if (io_any_i) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (one_strb) begin
            if (push_i) begin
              step_dn_o = 1'b1;
            end else if (pop_i) begin
              step_up_o = 1'b1;
            end else if (call_i) begin
              step_dn_o = 1'b1;
              st_d      = ST_CALL2;
            end else begin
              step_up_o = 1'b1;
              acc_hi_o  = 1'b1;
              st_d      = ST_RET2;
            end
          end
        end
        ST_CALL2: begin
          step_dn_o = 1'b1;
          acc_hi_o  = 1'b1;
          st_d      = ST_IDLE;
        end
        ST_RET2: begin
          step_up_o = 1'b1;
          st_d      = ST_IDLE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/sp_reg.sv
module sp_reg #(
  parameter int AW = 16,
  parameter int LW = 8,
  localparam int NL = AW / LW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] io_we_i,
  input  logic [LW-1:0] io_wdata_i,
  input  logic          step_dn_i,
  input  logic          step_up_i,
  output logic [AW-1:0] sp_o,
  output logic [AW-1:0] sp_step_o
);
  logic [AW-1:0] sp_q, sp_d;
  logic          en;

  always_comb begin
    if (step_up_i)      sp_step_o = sp_q + {{(AW-1){1'b0}}, 1'b1};
    else if (step_dn_i) sp_step_o = sp_q - {{(AW-1){1'b0}}, 1'b1};
    else                sp_step_o = sp_q;
  end

  for (genvar g = 0; g < NL; g++) begin : g_lane
    always_comb begin
      if (io_we_i[g]) sp_d[g*LW +: LW] = io_wdata_i;
      else            sp_d[g*LW +: LW] = sp_step_o[g*LW +: LW];
    end
  end

  assign en = (|io_we_i) || step_dn_i || step_up_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sp_q <= '0;
    else if (en) sp_q <= sp_d;
  end

  assign sp_o = sp_q;
endmodule

// File: rtl/sp_limit.sv
module sp_limit #(
  parameter int          AW    = 16,
  parameter logic [AW-1:0] LIMIT = 16'h0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  input  logic [AW-1:0] sp_next_i,
  output logic          flag_o
);
  logic flag_q, hit;

  assign hit = step_i && (sp_next_i <= LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (hit) flag_q <= 1'b1;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit #(
  parameter int            AW    = 16,
  parameter int            LW    = 8,
  parameter logic [AW-1:0] LIMIT = 16'h0100,
  localparam int           NL    = AW / LW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic [NL-1:0] io_we_i,
  input  logic [LW-1:0] io_wdata_i,
  output logic [AW-1:0] sp_rd_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_valid_o,
  output logic          mem_we_o,
  output logic          mem_hi_o,
  output logic          busy_o,
  output logic          op_err_o,
  output logic          limit_flag_o
);
  logic          step_dn, step_up, acc_hi;
  logic [AW-1:0] sp_q, sp_step;

  sp_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_i    (push_i),
    .pop_i     (pop_i),
    .call_i    (call_i),
    .ret_i     (ret_i),
    .io_any_i  (|io_we_i),
    .step_dn_o (step_dn),
    .step_up_o (step_up),
    .acc_hi_o  (acc_hi),
    .busy_o    (busy_o),
    .err_o     (op_err_o)
  );

  sp_reg #(.AW(AW), .LW(LW)) u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_we_i    (io_we_i),
    .io_wdata_i (io_wdata_i),
    .step_dn_i  (step_dn),
    .step_up_i  (step_up),
    .sp_o       (sp_q),
    .sp_step_o  (sp_step)
  );

  sp_limit #(.AW(AW), .LIMIT(LIMIT)) u_lim (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_i    (step_dn | step_up),
    .sp_next_i (sp_step),
    .flag_o    (limit_flag_o)
  );

  // push writes at the current pointer, pop reads at the raised pointer
  assign mem_addr_o  = step_up ? sp_step : sp_q;
  assign mem_valid_o = step_dn | step_up;
  assign mem_we_o    = step_dn;
  assign mem_hi_o    = acc_hi;
  assign sp_rd_o     = sp_q;
endmodule

// File: rtl/sp_checker.sv
module sp_checker #(
  parameter int AW = 16,
  parameter int LW = 8,
  localparam int NL = AW / LW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_i,
  input logic          pop_i,
  input logic          call_i,
  input logic          ret_i,
  input logic [NL-1:0] io_we_i,
  input logic [LW-1:0] io_wdata_i,
  input logic [AW-1:0] sp_rd_o,
  input logic          mem_valid_o,
  input logic          busy_o,
  input logic          op_err_o,
  input logic          limit_flag_o
);
  logic quiet, push_ok, pop_ok, call_ok;
  assign quiet   = !busy_o && (io_we_i == '0);
  assign push_ok = quiet && push_i && !pop_i && !call_i && !ret_i;
  assign pop_ok  = quiet && pop_i && !push_i && !call_i && !ret_i;
  assign call_ok = quiet && call_i && !push_i && !pop_i && !ret_i;

  a_r2_push_dec: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> (sp_rd_o == $past(sp_rd_o) - 1'b1));

  a_r3_pop_inc: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> (sp_rd_o == $past(sp_rd_o) + 1'b1));

  a_r4_call_busy: assert property (@(posedge clk) disable iff (!rst_n)
    call_ok |=> busy_o);

  a_r4_call_by_two: assert property (@(posedge clk) disable iff (!rst_n)
    (call_ok ##1 (io_we_i == '0)) |=> (sp_rd_o == $past(sp_rd_o, 2) - 2'd2));

  a_r7_lo_lane: assert property (@(posedge clk) disable iff (!rst_n)
    io_we_i[0] |=> (sp_rd_o[LW-1:0] == $past(io_wdata_i)));

  a_r7_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    (io_we_i != '0) |-> !mem_valid_o);

  a_r8_conflict: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && ($countones({push_i, pop_i, call_i, ret_i}) > 1)) |-> (op_err_o && !mem_valid_o));

  a_r8_conflict_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && ($countones({push_i, pop_i, call_i, ret_i}) > 1)) |=> $stable(sp_rd_o));

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    limit_flag_o |=> limit_flag_o);
endmodule

bind stack_ptr_unit sp_checker #(.AW(AW), .LW(LW)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .push_i       (push_i),
  .pop_i        (pop_i),
  .call_i       (call_i),
  .ret_i        (ret_i),
  .io_we_i      (io_we_i),
  .io_wdata_i   (io_wdata_i),
  .sp_rd_o      (sp_rd_o),
  .mem_valid_o  (mem_valid_o),
  .busy_o       (busy_o),
  .op_err_o     (op_err_o),
  .limit_flag_o (limit_flag_o)
);

// File: tb/test_stack_ptr_unit.sv
`timescale 1ns/1ps
module test_stack_ptr_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        push_i, pop_i, call_i, ret_i;
  logic [1:0]  io_we_i;
  logic [7:0]  io_wdata_i;
  logic [15:0] sp_rd_o, mem_addr_o;
  logic        mem_valid_o, mem_we_o, mem_hi_o, busy_o, op_err_o, limit_flag_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  stack_ptr_unit i_stack_ptr_unit (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i), .call_i(call_i),
    .ret_i(ret_i), .io_we_i(io_we_i), .io_wdata_i(io_wdata_i), .sp_rd_o(sp_rd_o),
    .mem_addr_o(mem_addr_o), .mem_valid_o(mem_valid_o), .mem_we_o(mem_we_o),
    .mem_hi_o(mem_hi_o), .busy_o(busy_o), .op_err_o(op_err_o), .limit_flag_o(limit_flag_o)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive inputs after the falling edge; combinational outputs are sampled before the rising edge
  task automatic drive(input logic p, input logic po, input logic c, input logic r,
                       input logic [1:0] we, input logic [7:0] wd);
    @(negedge clk);
    push_i = p; pop_i = po; call_i = c; ret_i = r; io_we_i = we; io_wdata_i = wd;
    #2;
  endtask

  task automatic finish_cycle();
    @(posedge clk);
    #1;
    push_i = 0; pop_i = 0; call_i = 0; ret_i = 0; io_we_i = 2'b00; io_wdata_i = 8'h00;
  endtask

  task automatic io_set(input logic [15:0] v);
    drive(0, 0, 0, 0, 2'b11, v[7:0]);
    finish_cycle();
    drive(0, 0, 0, 0, 2'b10, v[15:8]);
    finish_cycle();
  endtask

  task automatic t_reset();
    chk("R1 sp", sp_rd_o, 16'h0000);
    chk("R1 busy/err/valid/flag", {12'h0, busy_o, op_err_o, mem_valid_o, limit_flag_o}, 16'h0000);
  endtask

  task automatic t_io_lanes();
    drive(0, 0, 0, 0, 2'b01, 8'h50);
    finish_cycle();
    chk("R6 low lane", sp_rd_o, 16'h0050);
    chk("R10 io write no flag", {15'h0, limit_flag_o}, 16'h0000);
    drive(0, 0, 0, 0, 2'b10, 8'h12);
    finish_cycle();
    drive(0, 0, 0, 0, 2'b01, 8'h34);
    finish_cycle();
    chk("R6 both lanes", sp_rd_o, 16'h1234);
    drive(0, 0, 0, 0, 2'b10, 8'hAB);
    finish_cycle();
    chk("R6 high lane keeps low", sp_rd_o, 16'hAB34);
  endtask

  task automatic t_push_pop();
    drive(1, 0, 0, 0, 2'b00, 8'h00);
    chk("R2 push addr", mem_addr_o, 16'hAB34);
    chk("R2 push valid/we/hi", {13'h0, mem_valid_o, mem_we_o, mem_hi_o}, 16'h0006);
    finish_cycle();
    chk("R2 push result", sp_rd_o, 16'hAB33);
    drive(0, 1, 0, 0, 2'b00, 8'h00);
    chk("R3 pop addr", mem_addr_o, 16'hAB34);
    chk("R3 pop valid/we", {14'h0, mem_valid_o, mem_we_o}, 16'h0002);
    finish_cycle();
    chk("R3 pop result", sp_rd_o, 16'hAB34);
  endtask

  task automatic t_call_with_intrusion();
    drive(0, 0, 1, 0, 2'b00, 8'h00);
    chk("R4 call step1 addr", mem_addr_o, 16'hAB34);
    chk("R4 call step1 we/hi/busy", {13'h0, mem_we_o, mem_hi_o, busy_o}, 16'h0004);
    finish_cycle();
    drive(1, 0, 0, 0, 2'b00, 8'h00);   // push during busy
    chk("R4 call step2 addr", mem_addr_o, 16'hAB33);
    chk("R4 call step2 we/hi/busy", {13'h0, mem_we_o, mem_hi_o, busy_o}, 16'h0007);
    chk("R9 strobe while busy err", {15'h0, op_err_o}, 16'h0001);
    finish_cycle();
    chk("R4 call result", sp_rd_o, 16'hAB32);
    chk("R9 back to idle", {15'h0, busy_o}, 16'h0000);
  endtask

  task automatic t_ret();
    drive(0, 0, 0, 1, 2'b00, 8'h00);
    chk("R5 ret step1 addr", mem_addr_o, 16'hAB33);
    chk("R5 ret step1 we/hi/busy", {13'h0, mem_we_o, mem_hi_o, busy_o}, 16'h0002);
    finish_cycle();
    drive(0, 0, 0, 0, 2'b00, 8'h00);
    chk("R5 ret step2 addr", mem_addr_o, 16'hAB34);
    chk("R5 ret step2 valid/we/hi/busy", {12'h0, mem_valid_o, mem_we_o, mem_hi_o, busy_o}, 16'h0009);
    finish_cycle();
    chk("R5 ret result", sp_rd_o, 16'hAB34);
  endtask

  task automatic t_conflict();
    drive(1, 1, 0, 0, 2'b00, 8'h00);
    chk("R8 err/valid", {14'h0, op_err_o, mem_valid_o}, 16'h0002);
    finish_cycle();
    chk("R8 pointer held", sp_rd_o, 16'hAB34);
    drive(0, 0, 1, 1, 2'b00, 8'h00);
    chk("R8 call+ret err/valid/", {14'h0, op_err_o, mem_valid_o}, 16'h0002);
    finish_cycle();
    chk("R8 no sequence started", {15'h0, busy_o}, 16'h0000);
  endtask

  task automatic t_io_priority();
    drive(1, 0, 0, 0, 2'b01, 8'h00);
    chk("R7 push dropped valid", {15'h0, mem_valid_o}, 16'h0000);
    finish_cycle();
    chk("R7 io wins", sp_rd_o, 16'hAB00);
    drive(0, 0, 1, 0, 2'b00, 8'h00);
    finish_cycle();
    drive(0, 0, 0, 0, 2'b10, 8'h20);
    chk("R7 step2 cancelled valid", {15'h0, mem_valid_o}, 16'h0000);
    finish_cycle();
    chk("R7 cancelled pointer", sp_rd_o, 16'h20FF);
    chk("R7 idle after cancel", {15'h0, busy_o}, 16'h0000);
  endtask

  task automatic t_limit();
    chk("R10 flag clear before", {15'h0, limit_flag_o}, 16'h0000);
    io_set(16'h0102);
    drive(1, 0, 0, 0, 2'b00, 8'h00);
    finish_cycle();
    chk("R10 0x0101 no flag", {15'h0, limit_flag_o}, 16'h0000);
    drive(1, 0, 0, 0, 2'b00, 8'h00);
    finish_cycle();
    chk("R10 0x0100 sets flag", {15'h0, limit_flag_o}, 16'h0001);
    io_set(16'h8000);
    drive(0, 1, 0, 0, 2'b00, 8'h00);
    finish_cycle();
    chk("R10 flag sticky", {15'h0, limit_flag_o}, 16'h0001);
  endtask

  task automatic t_wrap();
    io_set(16'hFFFF);
    drive(0, 1, 0, 0, 2'b00, 8'h00);
    chk("R11 pop wrap addr", mem_addr_o, 16'h0000);
    finish_cycle();
    chk("R11 pop wrap result", sp_rd_o, 16'h0000);
    drive(1, 0, 0, 0, 2'b00, 8'h00);
    chk("R11 push at zero addr", mem_addr_o, 16'h0000);
    finish_cycle();
    chk("R11 push wrap result", sp_rd_o, 16'hFFFF);
    drive(0, 0, 0, 1, 2'b00, 8'h00);
    chk("R11 ret wrap addr1", mem_addr_o, 16'h0000);
    finish_cycle();
    drive(0, 0, 0, 0, 2'b00, 8'h00);
    chk("R11 ret wrap addr2", mem_addr_o, 16'h0001);
    finish_cycle();
    chk("R11 ret wrap result", sp_rd_o, 16'h0001);
  endtask

  initial begin
    rst_n = 1'b0;
    push_i = 0; pop_i = 0; call_i = 0; ret_i = 0; io_we_i = 2'b00; io_wdata_i = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_io_lanes();
    t_push_pop();
    t_call_with_intrusion();
    t_ret();
    t_conflict();
    t_io_priority();
    t_limit();
    t_wrap();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule